// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block holds a single accumulator register and four condition flags: carry, zero, sign and parity. When its operation strobe is high, a 3-bit function code picks one of eight operations that combine the accumulator with an argument bus. The surrounding datapath drives that bus with either a register value or immediate data. A second strobe makes the block rotate the accumulator by one bit in one of four ways. Two of the rotate styles are circular and two pass through the carry flag.

A 3-bit condition code is tested against the stored flags at all times, and the answer is a single true/false output. A branch unit can use it to decide conditional jumps, calls and returns. State changes only on a rising clock edge with a strobe asserted. A synchronous, active-high reset clears everything.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, the accumulator and all four flags are cleared to 0 at that edge.
- R2: With `alu_go` high, function code 000 loads A+arg into the accumulator and 001 loads A+arg+carry. Carry takes the carry out of the top bit.
- R3: With `alu_go` high, function code 010 loads A-arg and 011 loads A-arg-carry. Carry is set exactly when the subtraction borrows, meaning the unsigned minuend is smaller than the subtrahend plus any borrow-in.
- R4: With `alu_go` high, function code 100 loads A AND arg, 101 loads A XOR arg and 110 loads A OR arg. Each of these clears carry.
- R5: Function code 111 is a compare. It sets all four flags exactly as code 010 would, and it leaves the accumulator unchanged.
- R6: After any function-code operation, zero is 1 when the 8-bit result is 0, sign equals result bit 7, and parity is 1 when the result has an even number of one bits.
- R7: With `rot_go` high, `rot_sel` picks the rotate. 00 rotates left and copies bit 7 into both bit 0 and carry. 01 rotates right and copies bit 0 into both bit 7 and carry. 10 rotates left, moving the old carry into bit 0 and bit 7 into carry. 11 rotates right, moving the old carry into bit 7 and bit 0 into carry.
- R8: A rotate leaves the zero, sign and parity flags unchanged.
- R9: `cond_sel[1:0]` picks a flag: 00 carry, 01 zero, 10 sign, 11 parity. `cond_true` is 1 when that flag equals `cond_sel[2]`. So bit 2 = 0 tests for a clear flag (odd parity), and bit 2 = 1 tests for a set flag (even parity).
- R10: With neither strobe high, the accumulator and flags hold. When both strobes are high, only the function-code operation takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_go | input | 1 | Execute the function-code operation |
| func | input | 3 | Function code |
| arg | input | DATA_W | Argument (register or immediate data) |
| rot_go | input | 1 | Execute a rotate |
| rot_sel | input | 2 | Rotate kind |
| cond_sel | input | 3 | Condition code to evaluate |
| cond_true | output | 1 | Condition result from the current flags |
| acc | output | DATA_W | Accumulator value |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Parity flag (1 = even) |

## Verification
The bench uses the default `DATA_W` of 8. At that width, a few hundred random operands cover every carry-out and borrow case, along with all-zero and all-ones results and both parity states. Directed cases add the wrap cases 0xFF+1 and 0-1, an equal compare, carry-in on the add-with-carry and subtract-with-borrow codes, and each rotate with carry set and with carry clear. After every operation, all eight condition codes are swept against the flags the model predicts.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_ADC = 3'd1,
    FN_SUB = 3'd2,
    FN_SBB = 3'd3,
    FN_AND = 3'd4,
    FN_XOR = 3'd5,
    FN_OR  = 3'd6,
    FN_CMP = 3'd7
  } fn_e;

  typedef enum logic [1:0] {
    RT_LCIRC = 2'd0,
    RT_RCIRC = 2'd1,
    RT_LTHRU = 2'd2,
    RT_RTHRU = 2'd3
  } rot_e;

  typedef struct packed {
    logic cy;
    logic z;
    logic s;
    logic p;
  } flags_t;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  fn_e               fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              wr_acc
);

  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] a_x, b_x, c_x, wide;

  assign a_x = {1'b0, a};
  assign b_x = {1'b0, b};
  assign c_x = {{DATA_W{1'b0}}, cin};

  // subtraction in EXT_W bits: the top bit is the borrow
  always_comb begin
    unique case (fn)
      FN_ADD:         wide = a_x + b_x;
      FN_ADC:         wide = a_x + b_x + c_x;
      FN_SUB, FN_CMP: wide = a_x - b_x;
      FN_SBB:         wide = a_x - b_x - c_x;
      FN_AND:         wide = {1'b0, a & b};
      FN_XOR:         wide = {1'b0, a ^ b};
      FN_OR:          wide = {1'b0, a | b};
      default:        wide = '0;
    endcase
  end

  assign res    = wide[DATA_W-1:0];
  assign cout   = wide[DATA_W];
  assign wr_acc = (fn != FN_CMP);

endmodule

// File: rtl/acc_alu_rot.sv
module acc_alu_rot
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rot_e              sel,
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    unique case (sel)
      RT_LCIRC: begin res = {a[MSB-1:0], a[MSB]}; cout = a[MSB]; end
      RT_RCIRC: begin res = {a[0], a[MSB:1]};     cout = a[0];   end
      RT_LTHRU: begin res = {a[MSB-1:0], cin};    cout = a[MSB]; end
      RT_RTHRU: begin res = {cin, a[MSB:1]};      cout = a[0];   end
      default:  begin res = a;                    cout = cin;    end
    endcase
  end

endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
  import acc_alu_pkg::*;
(
  input  flags_t     flg,
  input  logic [2:0] code,
  output logic       hit
);

  logic picked;

  always_comb begin
    unique case (code[1:0])
      2'd0:    picked = flg.cy;
      2'd1:    picked = flg.z;
      2'd2:    picked = flg.s;
      default: picked = flg.p;
    endcase
  end

  // polarity bit: 1 tests for a set flag, 0 for a clear one
  assign hit = (picked == code[2]);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_go,
  input  logic [2:0]        func,
  input  logic [DATA_W-1:0] arg,
  input  logic              rot_go,
  input  logic [1:0]        rot_sel,
  input  logic [2:0]        cond_sel,
  output logic              cond_true,
  output logic [DATA_W-1:0] acc,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_p
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] acc_q;
  flags_t            flg_q;

  logic [DATA_W-1:0] alu_res, rot_res;
  logic              alu_cy, rot_cy, alu_wr;

  acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .fn     (fn_e'(func)),
    .a      (acc_q),
    .b      (arg),
    .cin    (flg_q.cy),
    .res    (alu_res),
    .cout   (alu_cy),
    .wr_acc (alu_wr)
  );

  acc_alu_rot #(.DATA_W(DATA_W)) u_rot (
    .sel  (rot_e'(rot_sel)),
    .a    (acc_q),
    .cin  (flg_q.cy),
    .res  (rot_res),
    .cout (rot_cy)
  );

  acc_alu_cond u_cond (
    .flg  (flg_q),
    .code (cond_sel),
    .hit  (cond_true)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (alu_go) begin
      if (alu_wr) acc_q <= alu_res;
      flg_q.cy <= alu_cy;
      flg_q.z  <= ~|alu_res;
      flg_q.s  <= alu_res[MSB];
      flg_q.p  <= ~^alu_res;
    end else if (rot_go) begin
      acc_q    <= rot_res;
      flg_q.cy <= rot_cy;
    end
  end

  assign acc    = acc_q;
  assign flag_c = flg_q.cy;
  assign flag_z = flg_q.z;
  assign flag_s = flg_q.s;
  assign flag_p = flg_q.p;

  // R5
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_go && func == 3'b111) |=> $stable(acc_q));

  // R4
  logic_clears_cy_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_go && func[2] && func != 3'b111) |=> !flg_q.cy);

  // R6
  zero_sign_track_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_go && func != 3'b111) |=> (flg_q.z == (acc_q == '0)) && (flg_q.s == acc_q[MSB]));

  // R8
  rot_keeps_zsp_chk: assert property (@(posedge clk) disable iff (rst)
    (rot_go && !alu_go) |=> $stable({flg_q.z, flg_q.s, flg_q.p}));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!alu_go && !rot_go) |=> ($stable(acc_q) && $stable(flg_q)));

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         alu_go, rot_go;
  logic [2:0]   func, cond_sel;
  logic [1:0]   rot_sel;
  logic [W-1:0] arg;
  logic         cond_true;
  logic [W-1:0] acc;
  logic         flag_c, flag_z, flag_s, flag_p;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  logic [W-1:0] m_a;
  logic         m_c, m_z, m_s, m_p;

  always #10 clk = ~clk;

  acc_alu #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .alu_go(alu_go), .func(func), .arg(arg),
    .rot_go(rot_go), .rot_sel(rot_sel), .cond_sel(cond_sel),
    .cond_true(cond_true), .acc(acc), .flag_c(flag_c), .flag_z(flag_z),
    .flag_s(flag_s), .flag_p(flag_p)
  );

  task automatic chk(input string tag, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  function automatic logic even_ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return (n % 2) == 0;
  endfunction

  task automatic model_alu(input int f, input logic [W-1:0] b);
    int a = int'(m_a), bb = int'(b), ci = int'(m_c), r = 0;
    logic [W-1:0] res;
    case (f)
      0: r = a + bb;
      1: r = a + bb + ci;
      2, 7: r = a - bb;
      3: r = a - bb - ci;
      4: r = a & bb;
      5: r = a ^ bb;
      default: r = a | bb;
    endcase
    res = W'(r);
    if (f < 2)       m_c = (r > 255);
    else if (f < 4 || f == 7) m_c = (r < 0);
    else             m_c = 1'b0;
    m_z = (res == 0);
    m_s = res[W-1];
    m_p = even_ones(res);
    if (f != 7) m_a = res;
  endtask

  task automatic model_rot(input int k);
    logic [W-1:0] a = m_a;
    logic oc = m_c;
    case (k)
      0: begin m_a = {a[W-2:0], a[W-1]}; m_c = a[W-1]; end
      1: begin m_a = {a[0], a[W-1:1]};   m_c = a[0];   end
      2: begin m_a = {a[W-2:0], oc};     m_c = a[W-1]; end
      default: begin m_a = {oc, a[W-1:1]}; m_c = a[0]; end
    endcase
  endtask

  task automatic check_state(input string ta, input string tc, input string tf);
    chk(ta, int'(acc), int'(m_a), "acc");
    chk(tc, int'(flag_c), int'(m_c), "carry");
    chk(tf, int'(flag_z), int'(m_z), "zero");
    chk(tf, int'(flag_s), int'(m_s), "sign");
    chk(tf, int'(flag_p), int'(m_p), "parity");
  endtask

  task automatic sweep_conds();
    logic fl;
    for (int c = 0; c < 8; c++) begin
      cond_sel = 3'(c);
      #1;
      case (c % 4)
        0: fl = m_c;
        1: fl = m_z;
        2: fl = m_s;
        default: fl = m_p;
      endcase
      // R9: polarity bit set tests for a set flag
      chk("R9", int'(cond_true), int'(fl == (c >= 4)), "cond_true");
    end
  endtask

  task automatic step(input logic ag, input logic rg, input int f,
                      input logic [W-1:0] b, input int k);
    string ta, tc, tf;
    @(negedge clk);
    alu_go = ag; rot_go = rg; func = 3'(f); arg = b; rot_sel = 2'(k);
    if (ag) begin
      if (f < 2)      ta = "R2";
      else if (f < 4) ta = "R3";
      else if (f < 7) ta = "R4";
      else            ta = "R5";
      tc = ta; tf = "R6";
      if (rg) ta = "R10";
      model_alu(f, b);
    end else if (rg) begin
      ta = "R7"; tc = "R7"; tf = "R8";
      model_rot(k);
    end else begin
      ta = "R10"; tc = "R10"; tf = "R10";
    end
    @(posedge clk); #1;
    check_state(ta, tc, tf);
    sweep_conds();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; alu_go = 0; rot_go = 0;
    @(posedge clk); #1;
    m_a = '0; m_c = 0; m_z = 0; m_s = 0; m_p = 0;
    check_state("R1", "R1", "R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int seed;
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    seed = 0;
  end

  initial begin
    int s = 32'h1234abcd;
    void'($urandom(s));
    rst = 1; alu_go = 0; rot_go = 0; func = 0; arg = 0; rot_sel = 0; cond_sel = 0;
    m_a = '0; m_c = 0; m_z = 0; m_s = 0; m_p = 0;
    do_reset();

    // R2 wrap to zero with carry out, then add with carry in
    step(1, 0, 0, 8'hFF, 0);   // acc 0 -> FF
    step(1, 0, 0, 8'h01, 0);   // FF+1 = 00, C=1
    step(1, 0, 1, 8'h10, 0);   // 0+10+1 = 11
    // R3 borrow cases
    step(1, 0, 2, 8'h12, 0);   // 11-12 = FF, borrow
    step(1, 0, 3, 8'h0F, 0);   // FF-0F-1 = EF
    // R5 equal compare keeps acc
    step(1, 0, 7, 8'hEF, 0);
    step(1, 0, 7, 8'hF0, 0);
    // R4 logical clears carry
    step(1, 0, 2, 8'hFF, 0);   // set borrow
    step(1, 0, 4, 8'h3C, 0);
    step(1, 0, 5, 8'hA5, 0);
    step(1, 0, 6, 8'h81, 0);
    // R7 each rotate with carry clear and set
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 4, 8'h00, 0); // clear carry, acc 0
      step(1, 0, 6, 8'h81, 0);
      step(0, 1, 0, 8'h00, k);
      step(1, 0, 0, 8'hFF, 0); // forces carry set
      step(0, 1, 0, 8'h00, k);
    end
    // R10 idle and both strobes
    step(0, 0, 0, 8'h55, 0);
    step(1, 1, 5, 8'h0F, 2);

    for (int i = 0; i < 400; i++) begin
      int pick = $urandom_range(0, 9);
      logic [W-1:0] b = W'($urandom);
      if (pick < 6)      step(1, 0, $urandom_range(0, 7), b, 0);
      else if (pick < 8) step(0, 1, 0, b, $urandom_range(0, 3));
      else if (pick < 9) step(0, 0, 0, b, 0);
      else               step(1, 1, $urandom_range(0, 7), b, $urandom_range(0, 3));
    end

    step(1, 0, 0, 8'h7E, 0);
    do_reset();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule